// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of already decoded operations whose operands are implicit. The working registers form a last-in-first-out stack of `DEPTH` entries. A push fetches a word from a synchronous data-memory read port and places it on top. A pop removes the top word and writes it to a memory address. A binary arithmetic or logic operation takes the two uppermost entries and replaces them with a single result. No operation carries a register specifier.

As an example, `A = B + C` runs as four operations: push B, push C, add, pop A. The two uppermost entries sit in dedicated registers, so a binary operation completes in one cycle. A push waits for the memory read-valid signal. While it waits, `busy` is high and new operations are refused. Stack underflow and stack overflow are reported as one-cycle error pulses. The stack is left as it was.

Top module: `stack_exec_unit`

## Requirements
- R1: After a synchronous active-low reset, `depth` is 0, `empty` is 1, and `full`, `busy`, `err_underflow` and `err_overflow` are all 0.
- R2: An accepted push (`op_code` 3'b001) with a non-full stack pulses `mem_rd_req` in its acceptance cycle with `mem_rd_addr` = `op_addr`. It holds `busy` high until `mem_rd_valid`. In the next cycle `tos` equals the returned data and `depth` has grown by one.
- R3: While `busy` is high, `op_valid` is ignored: no memory write or read request is issued and the stack is unchanged.
- R4: An accepted pop (`op_code` 3'b010) on a non-empty stack asserts `mem_wr_en` in its acceptance cycle with `mem_wr_addr` = `op_addr` and `mem_wr_data` = `tos`. In the next cycle the entry below becomes `tos` and `depth` drops by one.
- R5: Add (3'b011) replaces the two uppermost entries with their sum, modulo 2^DATA_W.
- R6: Subtract (3'b100) replaces them with the earlier-pushed entry minus the top entry, modulo 2^DATA_W.
- R7: AND (3'b101), OR (3'b110) and XOR (3'b111) replace the two uppermost entries with their bitwise combination.
- R8: A binary operation with fewer than two entries raises `err_underflow` for one cycle, in the cycle after acceptance, and leaves `depth` and `tos` unchanged.
- R9: A pop on an empty stack raises `err_underflow` for one cycle and issues no memory write.
- R10: A push on a full stack raises `err_overflow` for one cycle, issues no memory read request and leaves the stack unchanged.
- R11: `full` is high exactly when `depth` equals `DEPTH`. `empty` is high exactly when `depth` is 0.
- R12: Entries below the two uppermost registers keep their order, so popping a full stack returns the words in the reverse order of their pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 add, 4 sub, 5 and, 6 or, 7 xor |
| op_addr | input | ADDR_W | Memory address for push or pop |
| busy | output | 1 | Push waiting for memory; operations refused |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| tos | output | DATA_W | Current top-of-stack value |
| depth | output | $clog2(DEPTH+1) | Number of entries held |
| empty | output | 1 | Stack holds no entries |
| full | output | 1 | Stack holds DEPTH entries |
| err_underflow | output | 1 | One-cycle underflow pulse |
| err_overflow | output | 1 | One-cycle overflow pulse |

## Verification
The bench builds the unit with its defaults: DATA_W 16, DEPTH 8, ADDR_W 8. Its memory model answers each read two cycles after the request. With eight entries, a handful of pushes fills the stack. This brings the overflow boundary, a full reverse-order drain through the lower shift registers, and underflow from both empty and single-entry states within reach. The 16-bit width lets the memory words make subtraction wrap below zero.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
// Shared operation encoding for the stack execution unit.
// Assumes the upstream decoder delivers one of these 3-bit codes.
package stk_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } stk_op_e;

    // True for the operations that combine the two uppermost entries.
    function automatic logic is_binary(stk_op_e op);
        return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
    endfunction
endpackage

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
// Combinational two-operand unit.
// 'lower' is the entry pushed earlier, 'upper' is the top of stack.
// Assumes the caller uses the result only for binary operations.
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  stk_op_e             op,
    input  logic [DATA_W-1:0]   lower,
    input  logic [DATA_W-1:0]   upper,
    output logic [DATA_W-1:0]   result
);
    // Select the result for the requested operation.
    always_comb begin
        unique case (op)
            OP_ADD:  result = lower + upper;
            OP_SUB:  result = lower - upper;
            OP_AND:  result = lower & upper;
            OP_OR:   result = lower | upper;
            OP_XOR:  result = lower ^ upper;
            default: result = upper;
        endcase
    end
endmodule

// File: rtl/stk_regs.sv
`timescale 1ns/1ps
// Register stack: two dedicated uppermost registers plus a shift chain
// of DEPTH-2 lower entries, and an occupancy counter.
// Assumes at most one of push/pop/bin per cycle and that the controller
// has already screened out overflow and underflow.
module stk_regs #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                do_push,
    input  logic                do_pop,
    input  logic                do_bin,
    input  logic [DATA_W-1:0]   push_data,
    input  logic [DATA_W-1:0]   bin_data,
    output logic [DATA_W-1:0]   top,
    output logic [DATA_W-1:0]   second,
    output logic [DEPTH_W-1:0]  count
);
    localparam int LOW_N = DEPTH - 2;

    logic [DATA_W-1:0] low_q [LOW_N];
    logic              shrink;

    assign shrink = do_pop | do_bin;

    // Update the two uppermost registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top    <= '0;
            second <= '0;
        end else if (do_push) begin
            top    <= push_data;
            second <= top;
        end else if (do_pop) begin
            top    <= second;
            second <= low_q[0];
        end else if (do_bin) begin
            top    <= bin_data;
            second <= low_q[0];
        end
    end

    // Shift the lower entries down on growth and up on shrink.
    for (genvar i = 0; i < LOW_N; i++) begin : g_low
        logic [DATA_W-1:0] from_above;
        logic [DATA_W-1:0] from_below;
        if (i == 0) begin : g_first
            assign from_above = second;
        end else begin : g_rest
            assign from_above = low_q[i-1];
        end
        if (i == LOW_N - 1) begin : g_last
            assign from_below = '0;
        end else begin : g_inner
            assign from_below = low_q[i+1];
        end
        // Move one lower entry.
        always_ff @(posedge clk) begin
            if (!rst_n)       low_q[i] <= '0;
            else if (do_push) low_q[i] <= from_above;
            else if (shrink)  low_q[i] <= from_below;
        end
    end

    // Track the number of entries held.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (do_push) count <= count + 1'b1;
        else if (shrink)  count <= count - 1'b1;
    end

    a_r11_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_W'(DEPTH));
    a_r12_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_push, do_pop, do_bin}));
endmodule

// File: rtl/stack_exec_unit.sv
`timescale 1ns/1ps
// Zero-address execution unit: accepts decoded push/pop/ALU operations,
// keeps operands on a register stack, and reports stack errors.
// Assumes a memory that answers each read request with one valid pulse
// some cycles later, and that writes complete in their strobe cycle.
module stack_exec_unit
    import stk_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 8,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [ADDR_W-1:0]   op_addr,
    output logic                busy,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [DATA_W-1:0]   mem_rd_data,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    output logic [DATA_W-1:0]   tos,
    output logic [DEPTH_W-1:0]  depth,
    output logic                empty,
    output logic                full,
    output logic                err_underflow,
    output logic                err_overflow
);
    typedef enum logic {ST_IDLE, ST_WAIT} ctl_state_e;

    ctl_state_e        state_q;
    stk_op_e           op;
    logic              accept, binary;
    logic              push_go, pop_go, bin_go, land;
    logic              under_det, over_det;
    logic [DATA_W-1:0] second, alu_y;

    assign op      = stk_op_e'(op_code);
    assign binary  = is_binary(op);
    assign busy    = (state_q == ST_WAIT);
    assign accept  = op_valid && !busy;
    assign empty   = (depth == '0);
    assign full    = (depth == DEPTH_W'(DEPTH));

    assign push_go   = accept && (op == OP_PUSH) && !full;
    assign pop_go    = accept && (op == OP_POP) && !empty;
    assign bin_go    = accept && binary && (depth >= DEPTH_W'(2));
    assign under_det = accept && (((op == OP_POP) && empty) ||
                                  (binary && (depth < DEPTH_W'(2))));
    assign over_det  = accept && (op == OP_PUSH) && full;
    assign land      = busy && mem_rd_valid;

    assign mem_rd_req  = push_go;
    assign mem_rd_addr = op_addr;
    assign mem_wr_en   = pop_go;
    assign mem_wr_addr = op_addr;
    assign mem_wr_data = tos;

    // Wait for memory between a push request and its returned data.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= ST_IDLE;
        else if (push_go) state_q <= ST_WAIT;
        else if (land)    state_q <= ST_IDLE;
    end

    // Register one-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_underflow <= 1'b0;
            err_overflow  <= 1'b0;
        end else begin
            err_underflow <= under_det;
            err_overflow  <= over_det;
        end
    end

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (op),
        .lower  (second),
        .upper  (tos),
        .result (alu_y)
    );

    stk_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push   (land),
        .do_pop    (pop_go),
        .do_bin    (bin_go),
        .push_data (mem_rd_data),
        .bin_data  (alu_y),
        .top       (tos),
        .second    (second),
        .count     (depth)
    );

    a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rd_valid) |=>
            (depth == DEPTH_W'($past(depth) + 1'b1)) && (tos == $past(mem_rd_data)));
    a_r3_busy_blocks_memory: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_wr_en && !mem_rd_req));
    a_r8_underflow_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> ($stable(depth) && $stable(tos)));
    a_r9_write_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !empty);
    a_r10_overflow_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> (full && $stable(depth)));
endmodule

// File: tb/stack_exec_unit_test.sv
`timescale 1ns/1ps
module stack_exec_unit_test;
    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int AW = 8;
    localparam int DPW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [AW-1:0] op_addr = '0;
    logic busy, mem_rd_req, mem_rd_valid, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [DW-1:0] mem_rd_data, mem_wr_data, tos;
    logic [DPW-1:0] depth;
    logic empty, full, err_underflow, err_overflow;

    int total = 0;
    int fails = 0;
    int reads = 0;
    int lat = 0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] mdl[$];
    logic [AW-1:0] exp_wa[$];
    logic [DW-1:0] exp_wd[$];

    always #2.5 clk = ~clk;

    stack_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .tos(tos),
        .depth(depth), .empty(empty), .full(full),
        .err_underflow(err_underflow), .err_overflow(err_overflow)
    );

    function automatic logic [DW-1:0] memv(logic [AW-1:0] a);
        return DW'(a) * 16'd37 + 16'd5;
    endfunction

    // Memory model: answers each read two cycles after the request.
    always @(posedge clk) begin
        if (!rst_n) lat <= 0;
        else if (mem_rd_req) begin lat <= 2; raddr <= mem_rd_addr; end
        else if (lat != 0) lat <= lat - 1;
    end
    assign mem_rd_valid = (lat == 1);
    assign mem_rd_data  = memv(raddr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare every memory write against the scoreboard queue.
    always @(negedge clk) begin
        #1.25;
        if (rst_n && mem_rd_req) reads++;
        if (rst_n && mem_wr_en) begin
            if (exp_wa.size() == 0) chk(0, "R3/R9 unexpected write", int'(mem_wr_addr), -1);
            else begin
                logic [AW-1:0] ea;
                logic [DW-1:0] ed;
                ea = exp_wa.pop_front();
                ed = exp_wd.pop_front();
                chk(mem_wr_addr == ea, "R4 write address", int'(mem_wr_addr), int'(ea));
                chk(mem_wr_data == ed, "R4/R12 write data", int'(mem_wr_data), int'(ed));
            end
        end
    end

    task automatic check_stack(input string req);
        chk(depth == DPW'(mdl.size()), {req, " depth"}, int'(depth), mdl.size());
        if (mdl.size() != 0) chk(tos == mdl[$], {req, " tos"}, int'(tos), int'(mdl[$]));
        chk(full == (mdl.size() == DEPTH), "R11 full", int'(full), int'(mdl.size() == DEPTH));
        chk(empty == (mdl.size() == 0), "R11 empty", int'(empty), int'(mdl.size() == 0));
    endtask

    task automatic issue(input logic [2:0] code, input logic [AW-1:0] addr);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = addr;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_push(input logic [AW-1:0] addr, input bit poke);
        bit ovf;
        int r0;
        ovf = (mdl.size() == DEPTH);
        r0 = reads;
        issue(3'd1, addr);
        chk(err_overflow == ovf, "R10 overflow flag", int'(err_overflow), int'(ovf));
        chk(busy == !ovf, "R2 busy while waiting", int'(busy), int'(!ovf));
        if (poke && busy) begin
            op_valid = 1'b1; op_code = 3'd2; op_addr = 8'hEE;
            @(negedge clk);
            op_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        if (!ovf) mdl.push_back(memv(addr));
        chk(reads - r0 == (ovf ? 0 : 1), "R2/R10 read requests", reads - r0, ovf ? 0 : 1);
        check_stack(ovf ? "R10" : (poke ? "R3" : "R2"));
    endtask

    task automatic do_pop(input logic [AW-1:0] addr);
        bit und;
        und = (mdl.size() == 0);
        if (!und) begin
            exp_wa.push_back(addr);
            exp_wd.push_back(mdl.pop_back());
        end
        issue(3'd2, addr);
        chk(err_underflow == und, "R9 underflow flag", int'(err_underflow), int'(und));
        check_stack("R4");
    endtask

    task automatic do_bin(input logic [2:0] code, input string req);
        bit und;
        logic [DW-1:0] a, b, y;
        und = (mdl.size() < 2);
        if (!und) begin
            b = mdl.pop_back();
            a = mdl.pop_back();
            case (code)
                3'd3: y = a + b;
                3'd4: y = a - b;
                3'd5: y = a & b;
                3'd6: y = a | b;
                default: y = a ^ b;
            endcase
            mdl.push_back(y);
        end
        issue(code, 8'h00);
        chk(err_underflow == und, "R8 underflow flag", int'(err_underflow), int'(und));
        check_stack(und ? "R8" : req);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(depth == 0 && empty && !full && !busy && !err_underflow && !err_overflow,
            "R1 reset state", int'(depth), 0);
        rst_n = 1'b1;

        do_pop(8'h10);                 // R9 pop on empty
        do_bin(3'd3, "R5");            // R8 with no entries
        do_push(8'h20, 1'b0);          // R2
        do_bin(3'd4, "R6");            // R8 with one entry
        do_push(8'h21, 1'b0);
        do_bin(3'd3, "R5");            // add
        do_pop(8'h40);                 // R4 result written
        do_push(8'h02, 1'b0);
        do_push(8'h30, 1'b0);
        do_bin(3'd4, "R6");            // sub wraps below zero
        do_pop(8'h41);
        do_push(8'h55, 1'b0);
        do_push(8'h0F, 1'b0);
        do_bin(3'd5, "R7");            // and
        do_push(8'h33, 1'b0);
        do_bin(3'd6, "R7");            // or
        do_push(8'hA7, 1'b1);          // R3 pop ignored while busy
        do_bin(3'd7, "R7");            // xor
        do_pop(8'h42);
        for (int i = 0; i < DEPTH; i++) do_push(AW'(8'h60 + i), 1'b0);
        do_push(8'h99, 1'b0);          // R10 push on full
        for (int i = 0; i < DEPTH; i++) do_pop(AW'(8'h80 + i));  // R12 drain
        do_pop(8'h90);                 // R9 again
        repeat (3) @(negedge clk);
        chk(exp_wa.size() == 0, "R4 all writes seen", exp_wa.size(), 0);
        finish_up();
    end
endmodule